// File: doc/BRIEF.md
# Translation Context Control and Fault Register Bank

This block holds the per-context software-visible state of a multi-context I/O address translation unit. Each context owns a control word, a 40-bit translation-table base split over two words, a fault status word and a captured fault address split over two words. Software reaches them through a flat 32-bit register port. The bank turns each address into a context index and a register kind. Contexts 0 to 7 sit in a low window and contexts 8 and up sit in a second window that starts at 0x800.

The translation datapath talks to the bank through simple strobes. A fault strobe carries a context index, a set of fault kinds and the faulting address. An invalidate-done strobe carries the index of the context whose TLB invalidation has finished. The bank drives a per-context translation enable and a per-context invalidate request. It also drives one interrupt line, which combines every context whose interrupt enable is set and whose status holds a fault.

Top module: `xlat_ctx_regbank`

## Requirements
- R1: Register address = ctx*0x40 + offset for ctx 0..7, and ctx*0x40 + 0x600 + offset for ctx 8..15. The offsets are: control 0x00, table base low 0x10, table base high 0x14 (only bits 7:0 kept), status 0x20, fault address low 0x30, fault address high 0x34 (bits 7:0 = address bits 39:32).
- R2: Control bit 0 enables translation and bit 2 enables the interrupt. Both read back as written, and bit 0 drives `xlat_en[ctx]` from the cycle after the write.
- R3: Writing control with bit 1 set raises `inv_req[ctx]` from the next cycle, and control bit 1 then reads 1. Writing 0 to bit 1 does not cancel a pending request.
- R4: `inv_req[ctx]` stays high until `done_valid` arrives with `done_ctx` equal to ctx, and it is low the cycle after. A done strobe for another context has no effect. A new flush write in the same cycle as done leaves the request pending.
- R5: A fault strobe (`flt_valid`, `flt_ctx`, `flt_flags`) ORs its flags into status. The flag mapping is: `flt_flags[3]` to bit 4 (multiple hit), `[2]` to bit 2 (walk abort), `[1]` to bit 1 (permission), `[0]` to bit 0 (translation). Status bit 3 reads 0. A strobe with no flag set is ignored.
- R6: A fault that arrives while status is zero captures `flt_addr`. Later faults leave the captured address unchanged while status stays nonzero.
- R7: A status write leaves status = old status AND written data. Writing 0 clears every flag, and writing 1 to a flag keeps it. When the result is zero, both fault address words read 0.
- R8: If a fault arrives in the same cycle as a status write that leaves no flag set, the status holds the new fault's flags and the new fault's address.
- R9: `irq` is high exactly when some context has control bit 2 set and a nonzero status. It follows the register state of the previous edge.
- R10: Reads of unmapped offsets, of addresses 0x200 to 0x7FF, or of contexts at or above `NUM_CTX` return 0. Writes to them change no state.
- R11: After reset every register reads 0, and `inv_req`, `xlat_en` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| flt_valid | input | 1 | Fault report strobe |
| flt_ctx | input | 4 | Context index of the fault |
| flt_flags | input | 4 | Fault kinds {multi-hit, walk abort, permission, translation} |
| flt_addr | input | FA_W | Faulting address |
| done_valid | input | 1 | Invalidation-complete strobe |
| done_ctx | input | 4 | Context whose invalidation completed |
| inv_req | output | NUM_CTX | Pending invalidation per context |
| xlat_en | output | NUM_CTX | Translation enable per context |
| irq | output | 1 | Combined fault interrupt |

## Verification
Two pairs of functions can land on the same edge. The first is a software write to a context and a datapath strobe for that context: a zero status write together with a fault, or a flush write together with invalidate-done. The bench provokes both pairs in directed steps and then leaves them to chance in a long random phase in which writes, faults and done strobes often aim at the same context. An independent model in the bench applies the R4 and R8 precedence rules, and every output and a readback are compared against it after each edge.

// File: rtl/xlat_ctx_pkg.sv
package xlat_ctx_pkg;

  localparam int CTX_ID_W      = 4;
  localparam int MAX_CTX       = 16;
  localparam int CTX_STRIDE_SH = 6;       // 0x40 bytes per context
  localparam int LOW_WIN_CTX   = 8;       // contexts held in the low window
  localparam int HIGH_WIN_BASE = 'h800;   // first byte of the high window
  localparam int HIGH_WIN_SKEW = 'h600;   // added to ctx*0x40 above the low window

  localparam logic [5:0] OFF_CTRL   = 6'h00;
  localparam logic [5:0] OFF_TTB_LO = 6'h10;
  localparam logic [5:0] OFF_TTB_HI = 6'h14;
  localparam logic [5:0] OFF_STAT   = 6'h20;
  localparam logic [5:0] OFF_FA_LO  = 6'h30;
  localparam logic [5:0] OFF_FA_HI  = 6'h34;

  localparam int CB_EN    = 0;
  localparam int CB_FLUSH = 1;
  localparam int CB_IE    = 2;

  localparam int STAT_W = 5;
  localparam logic [STAT_W-1:0] STAT_MASK = 5'b10111;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_TTB_LO,
    RK_TTB_HI,
    RK_STAT,
    RK_FA_LO,
    RK_FA_HI
  } reg_kind_e;

endpackage

// File: rtl/xlat_ctx_decode.sv
module xlat_ctx_decode
  import xlat_ctx_pkg::*;
#(
  parameter int NUM_CTX = 16,
  parameter int ADDR_W  = 12
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CTX-1:0] ctx_sel,
  output reg_kind_e          kind
);

  localparam int IDX_W = ADDR_W - CTX_STRIDE_SH;
  localparam logic [ADDR_W-1:0] LOW_END = ADDR_W'(LOW_WIN_CTX << CTX_STRIDE_SH);
  localparam logic [ADDR_W-1:0] HI_BASE = ADDR_W'(HIGH_WIN_BASE);
  localparam logic [ADDR_W-1:0] HI_SKEW = ADDR_W'(HIGH_WIN_SKEW);

  logic              in_low;
  logic              in_high;
  logic [ADDR_W-1:0] rebased;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    in_low  = (addr < LOW_END);
    in_high = (addr >= HI_BASE);
    rebased = in_high ? (addr - HI_SKEW) : addr;
    idx     = rebased[ADDR_W-1:CTX_STRIDE_SH];
  end

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_sel
    assign ctx_sel[i] = (in_low || in_high) && (idx == IDX_W'(i));
  end

  always_comb begin
    unique case (addr[CTX_STRIDE_SH-1:0])
      OFF_CTRL:   kind = RK_CTRL;
      OFF_TTB_LO: kind = RK_TTB_LO;
      OFF_TTB_HI: kind = RK_TTB_HI;
      OFF_STAT:   kind = RK_STAT;
      OFF_FA_LO:  kind = RK_FA_LO;
      OFF_FA_HI:  kind = RK_FA_HI;
      default:    kind = RK_NONE;
    endcase
  end

endmodule

// File: rtl/xlat_ctx_slot.sv
module xlat_ctx_slot
  import xlat_ctx_pkg::*;
#(
  parameter int TTB_HI_W = 8,
  parameter int FA_W     = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_kind_e       kind,
  input  logic [31:0]     wdata,
  input  logic            flt_hit,
  input  logic [3:0]      flt_flags,
  input  logic [FA_W-1:0] flt_addr,
  input  logic            done_hit,
  output logic [31:0]     rdata,
  output logic            inv_req,
  output logic            xlat_en,
  output logic            irq_req
);

  logic                ie_q, en_q, pend_q;
  logic                ie_d, en_d, pend_d;
  logic [31:0]         ttb_lo_q;
  logic [TTB_HI_W-1:0] ttb_hi_q;
  logic [STAT_W-1:0]   stat_q, stat_d, stat_kept, flt_bits;
  logic [FA_W-1:0]     fa_q, fa_d;

  logic we_ctrl, we_tlo, we_thi, we_stat, flt_take;
  logic en_ctrl, en_stat;

  assign we_ctrl  = wr_en && (kind == RK_CTRL);
  assign we_tlo   = wr_en && (kind == RK_TTB_LO);
  assign we_thi   = wr_en && (kind == RK_TTB_HI);
  assign we_stat  = wr_en && (kind == RK_STAT);
  assign flt_take = flt_hit && (|flt_flags);
  assign flt_bits = {flt_flags[3], 1'b0, flt_flags[2:0]};

  assign en_ctrl  = we_ctrl || done_hit;
  assign en_stat  = we_stat || flt_take;

  // next state
  always_comb begin
    ie_d   = ie_q;
    en_d   = en_q;
    pend_d = pend_q && !done_hit;
    if (we_ctrl) begin
      ie_d = wdata[CB_IE];
      en_d = wdata[CB_EN];
      if (wdata[CB_FLUSH]) pend_d = 1'b1;
    end

    stat_kept = we_stat ? (stat_q & wdata[STAT_W-1:0] & STAT_MASK) : stat_q;
    stat_d    = stat_kept | (flt_take ? flt_bits : '0);
    fa_d      = fa_q;
    if (stat_kept == '0) fa_d = flt_take ? flt_addr : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      ttb_lo_q <= '0;
      ttb_hi_q <= '0;
      stat_q   <= '0;
      fa_q     <= '0;
    end else begin
      if (en_ctrl) begin
        ie_q   <= ie_d;
        en_q   <= en_d;
        pend_q <= pend_d;
      end
      if (we_tlo) ttb_lo_q <= wdata;
      if (we_thi) ttb_hi_q <= wdata[TTB_HI_W-1:0];
      if (en_stat) begin
        stat_q <= stat_d;
        fa_q   <= fa_d;
      end
    end
  end

  always_comb begin
    unique case (kind)
      RK_CTRL:   rdata = 32'({ie_q, pend_q, en_q});
      RK_TTB_LO: rdata = ttb_lo_q;
      RK_TTB_HI: rdata = 32'(ttb_hi_q);
      RK_STAT:   rdata = 32'(stat_q);
      RK_FA_LO:  rdata = fa_q[31:0];
      RK_FA_HI:  rdata = 32'(fa_q[FA_W-1:32]);
      default:   rdata = '0;
    endcase
  end

  assign inv_req = pend_q;
  assign xlat_en = en_q;
  assign irq_req = ie_q && (|stat_q);

  // R3: a flush write makes the request visible on the next cycle
  p_flush_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == RK_CTRL && wdata[CB_FLUSH]) |=> inv_req);

  // R4: request held until its own done strobe
  p_flush_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !done_hit) |=> inv_req);

  // R4: done without a fresh flush drops the request
  p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && done_hit && !(wr_en && kind == RK_CTRL && wdata[CB_FLUSH])) |=> !inv_req);

  // R5: reported fault kinds appear in status
  p_fault_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_hit && (|flt_flags)) |=> ((stat_q & $past(flt_bits)) == $past(flt_bits)));

  // R6: captured address stable while flags remain and no status write
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stat_q) && !(wr_en && kind == RK_STAT)) |=> $stable(fa_q));

  // R7: zero write without a fault empties status and address
  p_clear_wipes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == RK_STAT && wdata[STAT_W-1:0] == '0 && !flt_hit) |=> (stat_q == '0 && fa_q == '0));

endmodule

// File: rtl/xlat_ctx_regbank.sv
module xlat_ctx_regbank
  import xlat_ctx_pkg::*;
#(
  parameter int NUM_CTX = 16,
  parameter int ADDR_W  = 12,
  parameter int OUT_AW  = 40,
  parameter int FA_W    = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                flt_valid,
  input  logic [CTX_ID_W-1:0] flt_ctx,
  input  logic [3:0]          flt_flags,
  input  logic [FA_W-1:0]     flt_addr,
  input  logic                done_valid,
  input  logic [CTX_ID_W-1:0] done_ctx,
  output logic [NUM_CTX-1:0]  inv_req,
  output logic [NUM_CTX-1:0]  xlat_en,
  output logic                irq
);

  localparam int TTB_HI_W = OUT_AW - 32;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NUM_CTX-1:0] ctx_sel;
  reg_kind_e          kind;
  logic [31:0]        slot_rd [NUM_CTX];
  logic [NUM_CTX-1:0] irq_vec;

  xlat_ctx_decode #(
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .addr    (reg_addr),
    .ctx_sel (ctx_sel),
    .kind    (kind)
  );

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
    xlat_ctx_slot #(
      .TTB_HI_W (TTB_HI_W),
      .FA_W     (FA_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .wr_en     (reg_we && ctx_sel[i]),
      .kind      (kind),
      .wdata     (reg_wdata),
      .flt_hit   (flt_valid && (flt_ctx == CTX_ID_W'(i))),
      .flt_flags (flt_flags),
      .flt_addr  (flt_addr),
      .done_hit  (done_valid && (done_ctx == CTX_ID_W'(i))),
      .rdata     (slot_rd[i]),
      .inv_req   (inv_req[i]),
      .xlat_en   (xlat_en[i]),
      .irq_req   (irq_vec[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (ctx_sel[i]) reg_rdata = reg_rdata | slot_rd[i];
    end
  end

  assign irq = |irq_vec;

  // R10: at most one context answers any address
  p_one_ctx_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(ctx_sel));

  // R11: nothing pending straight out of reset
  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (inv_req == '0 && !irq));

endmodule

// File: tb/xlat_ctx_regbank_bench.sv
module xlat_ctx_regbank_bench;
  import xlat_ctx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 12;
  localparam int AW   = 12;
  localparam int FAW  = 40;
  localparam int NRAND = 4000;

  logic            clk;
  logic            rst_n;
  logic [AW-1:0]   reg_addr;
  logic            reg_we;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic            flt_valid;
  logic [3:0]      flt_ctx;
  logic [3:0]      flt_flags;
  logic [FAW-1:0]  flt_addr;
  logic            done_valid;
  logic [3:0]      done_ctx;
  logic [NCTX-1:0] inv_req;
  logic [NCTX-1:0] xlat_en;
  logic            irq;

  xlat_ctx_regbank #(
    .NUM_CTX (NCTX),
    .ADDR_W  (AW),
    .OUT_AW  (40),
    .FA_W    (FAW)
  ) u_xlat_ctx_regbank (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .flt_valid  (flt_valid),
    .flt_ctx    (flt_ctx),
    .flt_flags  (flt_flags),
    .flt_addr   (flt_addr),
    .done_valid (done_valid),
    .done_ctx   (done_ctx),
    .inv_req    (inv_req),
    .xlat_en    (xlat_en),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit        m_ie   [16];
  bit        m_en   [16];
  bit        m_pend [16];
  bit [31:0] m_tlo  [16];
  bit [7:0]  m_thi  [16];
  bit [4:0]  m_st   [16];
  bit [39:0] m_fa   [16];

  int n_chk;
  int n_fail;
  bit done_flag;

  function automatic logic [AW-1:0] caddr(int c, logic [5:0] off);
    int a;
    a = (c < 8) ? (c * 64 + off) : (c * 64 + 'h600 + off);
    return AW'(a);
  endfunction

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    for (int c = 0; c < NCTX; c++) begin
      if (a == caddr(c, 6'h00)) return {29'd0, m_ie[c], m_pend[c], m_en[c]};
      if (a == caddr(c, 6'h10)) return m_tlo[c];
      if (a == caddr(c, 6'h14)) return {24'd0, m_thi[c]};
      if (a == caddr(c, 6'h20)) return {27'd0, m_st[c]};
      if (a == caddr(c, 6'h30)) return m_fa[c][31:0];
      if (a == caddr(c, 6'h34)) return {24'd0, m_fa[c][39:32]};
    end
    return 32'd0;
  endfunction

  function automatic logic [NCTX-1:0] model_inv();
    logic [NCTX-1:0] v;
    for (int c = 0; c < NCTX; c++) v[c] = m_pend[c];
    return v;
  endfunction

  function automatic logic [NCTX-1:0] model_en();
    logic [NCTX-1:0] v;
    for (int c = 0; c < NCTX; c++) v[c] = m_en[c];
    return v;
  endfunction

  function automatic logic model_irq();
    logic r;
    r = 1'b0;
    for (int c = 0; c < NCTX; c++) r = r | (m_ie[c] & (|m_st[c]));
    return r;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_we     = 1'b0;
    reg_wdata  = '0;
    flt_valid  = 1'b0;
    flt_ctx    = '0;
    flt_flags  = '0;
    flt_addr   = '0;
    done_valid = 1'b0;
    done_ctx   = '0;
  endtask

  // one clock: inputs set at negedge, model follows the edge
  task automatic cycle();
    logic [AW-1:0]  a;
    logic           we, fv, dv;
    logic [31:0]    wd;
    logic [3:0]     fc, ff, dc;
    logic [FAW-1:0] fad;
    bit             d_c, f_c;
    bit [4:0]       kept;
    a = reg_addr; we = reg_we; wd = reg_wdata;
    fv = flt_valid; fc = flt_ctx; ff = flt_flags; fad = flt_addr;
    dv = done_valid; dc = done_ctx;
    @(posedge clk);
    for (int c = 0; c < NCTX; c++) begin
      d_c = dv && (int'(dc) == c);
      f_c = fv && (int'(fc) == c) && (|ff);
      if (we && a == caddr(c, 6'h00)) begin
        m_ie[c] = wd[2];
        m_en[c] = wd[0];
        m_pend[c] = wd[1] ? 1'b1 : (m_pend[c] && !d_c);
      end else if (d_c) begin
        m_pend[c] = 1'b0;
      end
      if (we && a == caddr(c, 6'h10)) m_tlo[c] = wd;
      if (we && a == caddr(c, 6'h14)) m_thi[c] = wd[7:0];
      kept = (we && a == caddr(c, 6'h20)) ? (m_st[c] & wd[4:0] & 5'b10111) : m_st[c];
      m_st[c] = kept | (f_c ? {ff[3], 1'b0, ff[2:0]} : 5'd0);
      if (kept == 5'd0) m_fa[c] = f_c ? fad : 40'd0;
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    cycle();
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a);
    reg_addr = a;
    #1;
    chk(req, $sformatf("read 0x%0h", a), 64'(reg_rdata), 64'(model_read(a)));
  endtask

  task automatic rd_exp(string req, logic [AW-1:0] a, logic [31:0] e);
    reg_addr = a;
    #1;
    chk(req, $sformatf("read 0x%0h", a), 64'(reg_rdata), 64'(e));
  endtask

  task automatic out_chk(string req);
    #1;
    chk(req, "irq", 64'(irq), 64'(model_irq()));
    chk(req, "inv_req", 64'(inv_req), 64'(model_inv()));
    chk(req, "xlat_en", 64'(xlat_en), 64'(model_en()));
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [5:0] offs [8];
    int c;
    int pick;
    logic [AW-1:0] ra;
    n_chk = 0; n_fail = 0; done_flag = 1'b0;
    offs = '{6'h00, 6'h10, 6'h14, 6'h20, 6'h30, 6'h34, 6'h04, 6'h24};
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0;
    reg_addr = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    rd_exp("R11", caddr(0, 6'h00), 32'd0);
    rd_exp("R11", caddr(5, 6'h20), 32'd0);
    rd_exp("R11", caddr(9, 6'h30), 32'd0);
    chk("R11", "irq", 64'(irq), 64'd0);
    chk("R11", "inv_req", 64'(inv_req), 64'd0);

    // R1 R2 R3 high window control
    wr(12'h840, 32'h7);
    rd_exp("R2", 12'h840, 32'h7);
    chk("R2", "xlat_en[9]", 64'(xlat_en[9]), 64'd1);
    chk("R3", "inv_req[9]", 64'(inv_req[9]), 64'd1);
    wr(12'h840, 32'h5);
    rd_exp("R3", 12'h840, 32'h7);

    // R4 done for another context, then its own
    done_valid = 1'b1; done_ctx = 4'd3; cycle();
    chk("R4", "inv_req[9] other done", 64'(inv_req[9]), 64'd1);
    done_valid = 1'b1; done_ctx = 4'd9; cycle();
    chk("R4", "inv_req[9] own done", 64'(inv_req[9]), 64'd0);
    rd_exp("R4", 12'h840, 32'h5);
    // R4 flush write and done on the same edge
    reg_addr = 12'h840; reg_we = 1'b1; reg_wdata = 32'h7;
    done_valid = 1'b1; done_ctx = 4'd9; cycle();
    chk("R4", "inv_req[9] collide", 64'(inv_req[9]), 64'd1);
    done_valid = 1'b1; done_ctx = 4'd9; cycle();
    out_chk("R4");

    // R5 R6 R9 faults
    flt_valid = 1'b1; flt_ctx = 4'd9; flt_flags = 4'b0001; flt_addr = 40'hAB_1234_5678; cycle();
    rd_exp("R5", 12'h860, 32'h01);
    rd_exp("R6", 12'h870, 32'h1234_5678);
    rd_exp("R6", 12'h874, 32'hAB);
    chk("R9", "irq", 64'(irq), 64'd1);
    flt_valid = 1'b1; flt_ctx = 4'd9; flt_flags = 4'b1000; flt_addr = 40'h11_2222_3333; cycle();
    rd_exp("R5", 12'h860, 32'h11);
    rd_exp("R6", 12'h870, 32'h1234_5678);
    flt_valid = 1'b1; flt_ctx = 4'd2; flt_flags = 4'b0100; flt_addr = 40'h00_0000_0040; cycle();
    rd_exp("R5", caddr(2, 6'h20), 32'h04);

    // R7 masked status writes
    wr(12'h860, 32'h1);
    rd_exp("R7", 12'h860, 32'h01);
    rd_exp("R7", 12'h870, 32'h1234_5678);
    wr(12'h860, 32'h0);
    rd_exp("R7", 12'h860, 32'h0);
    rd_exp("R7", 12'h870, 32'h0);
    rd_exp("R7", 12'h874, 32'h0);
    chk("R9", "irq without enable", 64'(irq), 64'd0);

    // R8 clear and fault together
    reg_addr = caddr(2, 6'h20); reg_we = 1'b1; reg_wdata = 32'h0;
    flt_valid = 1'b1; flt_ctx = 4'd2; flt_flags = 4'b0010; flt_addr = 40'h5A_0BAD_F00D; cycle();
    rd_exp("R8", caddr(2, 6'h20), 32'h02);
    rd_exp("R8", caddr(2, 6'h30), 32'h0BAD_F00D);
    rd_exp("R8", caddr(2, 6'h34), 32'h5A);

    // R5 empty fault ignored
    flt_valid = 1'b1; flt_ctx = 4'd4; flt_flags = 4'b0000; flt_addr = 40'h77_7777_7777; cycle();
    rd_exp("R5", caddr(4, 6'h20), 32'h0);
    rd_exp("R5", caddr(4, 6'h30), 32'h0);

    // R1 table base and window edges
    wr(12'h010, 32'hDEAD_BEEF);
    wr(12'h014, 32'hFFFF_FFFF);
    rd_exp("R1", 12'h010, 32'hDEAD_BEEF);
    rd_exp("R1", 12'h014, 32'h0000_00FF);
    wr(12'h800, 32'h1);
    rd_exp("R1", 12'h800, 32'h1);
    chk("R1", "xlat_en[8]", 64'(xlat_en[8]), 64'd1);
    rd_exp("R1", 12'h200, 32'h0);

    // R10 unmapped accesses
    wr(caddr(15, 6'h00), 32'h7);
    rd_exp("R10", caddr(15, 6'h00), 32'h0);
    wr(12'h400, 32'hFFFF_FFFF);
    rd_exp("R10", 12'h400, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    rd_exp("R10", 12'h004, 32'h0);
    out_chk("R10");

    // random phase, aimed at a few contexts so collisions are common
    for (int k = 0; k < NRAND; k++) begin
      c = ($urandom % 4 == 0) ? int'($urandom % 16) : int'(8 + $urandom % 3);
      pick = int'($urandom % 8);
      ra = ($urandom % 16 == 0) ? AW'(12'h200 + ($urandom % 12'h600)) : caddr(c, offs[pick]);
      reg_addr  = ra;
      reg_we    = ($urandom % 3 == 0);
      reg_wdata = ($urandom % 2 == 0) ? ($urandom % 32) : $urandom;
      flt_valid = ($urandom % 4 == 0);
      flt_ctx   = ($urandom % 2 == 0) ? 4'(c) : 4'($urandom);
      flt_flags = 4'($urandom);
      flt_addr  = {8'($urandom), 32'($urandom)};
      done_valid = ($urandom % 4 == 0);
      done_ctx   = ($urandom % 2 == 0) ? 4'(c) : 4'($urandom);
      cycle();
      out_chk("R9");
      pick = int'($urandom % 8);
      rd_chk("R10", caddr(c, offs[pick]));
    end

    summary();
  end

endmodule